// File: doc/BRIEF.md
# Sensor Monitor Register Front-End

This block is a bus-slave register file placed between a simple processor bus and an analog sensor converter. Software programs three configuration words and a channel sequence word. The block forwards the mode, channel, clock-divide and committed sequence fields to the converter. It also drives a conversion trigger, which is the OR of a software start bit and an external start pin, gated by the event-driven mode bit.

The converter reports completions through a handshake port. An end-of-conversion pulse stores the 16-bit converter word into the result register of the reported channel and raises a status flag. An end-of-sequence pulse raises a second flag. Reading the status register clears both flags. Writing a key value to the reset register starts an internal reset that lasts a fixed number of cycles. That reset clears every register and is also forwarded to the converter.

The soft-reset controller is a two-state machine. In state `RS_RUN` the block operates normally. The transition *key accepted* moves it to `RS_HOLD` when the key register is written with the key. `RS_HOLD` keeps the internal reset asserted while a counter runs down. The transition *count expired* returns it to `RS_RUN` when the counter reaches zero. In `RS_HOLD` every bus write is ignored, and that includes a repeated key write.

Top module: `smon_regfile`

## Requirements
- R1: After `rst_n` is released, `cnv_rst` is 0 and every readable register reads 0: configuration words, sequence word, status and results.
- R2: A bus write of 0x0000000A to offset 0x000 holds `cnv_rst` at 1 for exactly 16 consecutive cycles, beginning in the cycle after the write. A write of any other value to that offset leaves `cnv_rst` at 0 and leaves all registers unchanged.
- R3: While `cnv_rst` is 1, the configuration words, the sequence words and the start bit are forced to zero, and bus writes to them have no effect.
- R4: `cnv_single` is 1 exactly when bits 13 and 12 of configuration word 1 (offset 0x104) are both 1.
- R5: `cnv_cont` is the inverse of the event-driven bit, which is bit 9 of configuration word 0 (offset 0x100). `cnv_chan` carries bits 4:0 of that word.
- R6: When the event-driven bit is 1, `cnv_trig` is the OR of start-register bit 0 (offset 0x010) and `ext_start`. When the event-driven bit is 0, `cnv_trig` is 0.
- R7: The status register (offset 0x014) has the end-of-conversion flag in bit 0 and the end-of-sequence flag in bit 1. A `cv_eoc` or `cv_eos` pulse sets its flag from the next cycle onward. A bus read of the status register returns the flags and then clears both of them.
- R8: If a status read and a completion pulse fall in the same cycle, the read returns the old flag value and the flag is left set.
- R9: On a `cv_eoc` pulse, `cv_data` is stored for channel `cv_chan`. Results for channels 0 to 3 read at offsets 0x200, 0x204, 0x208 and 0x20C, with the 16-bit word in bits 15:0 and zeros in bits 31:16.
- R10: A write to the sequence word (offset 0x120) is read back at that offset but does not change `cnv_seq`. The next write to configuration word 1 copies the stored sequence to `cnv_seq`.
- R11: `cnv_div` carries bits 15:8 of configuration word 2 (offset 0x108). Writing 0x2000 therefore gives a divide ratio of 32.
- R12: Configuration words 0, 1 and 2 read back the full 32-bit value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (status read clears flags) |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| ext_start | input | 1 | External conversion start pin |
| cnv_rst | output | 1 | Stretched soft reset to the converter |
| cnv_single | output | 1 | Single-channel mode selected |
| cnv_cont | output | 1 | Continuous sampling selected |
| cnv_chan | output | 5 | Selected channel |
| cnv_div | output | 8 | Converter clock divide ratio |
| cnv_seq | output | 16 | Committed channel sequence |
| cnv_trig | output | 1 | Conversion trigger |
| cv_eoc | input | 1 | End-of-conversion pulse from converter |
| cv_eos | input | 1 | End-of-sequence pulse from converter |
| cv_chan | input | 2 | Channel of the finished conversion |
| cv_data | input | 16 | Converted word |

## Verification
The two functions that can meet in one cycle are the status read-clear and a converter completion pulse. The bench raises `cv_eoc` in the same cycle as a status read strobe. It expects the old flag value on `bus_rdata` in that cycle and a set flag on the next read, which must then clear it. A second collision, a configuration write issued while the keyed reset is still holding, is judged by reading the register back as zero once the hold ends.

// File: rtl/smon_pkg.sv
package smon_pkg;

    typedef enum logic [0:0] {
        RS_RUN  = 1'b0,
        RS_HOLD = 1'b1
    } rst_state_t;

    localparam logic [11:0] OFF_KEY   = 12'h000;
    localparam logic [11:0] OFF_START = 12'h010;
    localparam logic [11:0] OFF_STAT  = 12'h014;
    localparam logic [11:0] OFF_CFG0  = 12'h100;
    localparam logic [11:0] OFF_CFG1  = 12'h104;
    localparam logic [11:0] OFF_CFG2  = 12'h108;
    localparam logic [11:0] OFF_SEQ   = 12'h120;
    localparam logic [11:0] OFF_RES   = 12'h200;

    localparam int BIT_EVENT = 9;
    localparam int BIT_SEQ_HI = 13;
    localparam int BIT_SEQ_LO = 12;
    localparam int DIV_LO = 8;
    localparam int CHAN_W = 5;

endpackage

// File: rtl/smon_softrst.sv
module smon_softrst #(
    parameter int          DATA_W  = 32,
    parameter int          RST_LEN = 16,
    parameter logic [31:0] KEY     = 32'h0000_000A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    output logic              srst
);
    import smon_pkg::*;

    localparam int CNT_W = (RST_LEN > 1) ? $clog2(RST_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_LEN - 1);

    rst_state_t     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic           key_hit;

    assign key_hit = key_wr && (key_data == DATA_W'(KEY));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state logic: key accepted / count expired
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RS_RUN: begin
                if (key_hit) begin
                    state_d = RS_HOLD;
                    cnt_d   = CNT_LAST;
                end
            end
            RS_HOLD: begin
                if (cnt_q == '0) begin
                    state_d = RS_RUN;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = RS_RUN;
        endcase
    end

    // outputs
    always_comb begin
        srst = 1'b0;
        unique case (state_q)
            RS_RUN:  srst = 1'b0;
            RS_HOLD: srst = 1'b1;
            default: srst = 1'b0;
        endcase
    end

    assert_key_enters_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst && key_hit) |=> srst);
    assert_hold_continues_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (srst && cnt_q != '0) |=> srst);
    assert_wrong_key_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst && !key_hit) |=> !srst);

endmodule

// File: rtl/smon_cfg.sv
module smon_cfg #(
    parameter int DATA_W = 32,
    parameter int SEQ_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              wr_cfg0,
    input  logic              wr_cfg1,
    input  logic              wr_cfg2,
    input  logic              wr_seq,
    input  logic              wr_start,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cfg0_q,
    output logic [DATA_W-1:0] cfg1_q,
    output logic [DATA_W-1:0] cfg2_q,
    output logic [SEQ_W-1:0]  seq_pend_q,
    output logic [SEQ_W-1:0]  seq_live_q,
    output logic              start_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg0_q     <= '0;
            cfg1_q     <= '0;
            cfg2_q     <= '0;
            seq_pend_q <= '0;
            seq_live_q <= '0;
            start_q    <= 1'b0;
        end else if (srst) begin
            cfg0_q     <= '0;
            cfg1_q     <= '0;
            cfg2_q     <= '0;
            seq_pend_q <= '0;
            seq_live_q <= '0;
            start_q    <= 1'b0;
        end else begin
            if (wr_cfg0)  cfg0_q     <= wdata;
            if (wr_cfg2)  cfg2_q     <= wdata;
            if (wr_seq)   seq_pend_q <= wdata[SEQ_W-1:0];
            if (wr_start) start_q    <= wdata[0];
            if (wr_cfg1) begin
                cfg1_q     <= wdata;
                seq_live_q <= seq_pend_q;
            end
        end
    end

    assert_srst_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (cfg0_q == '0 && cfg1_q == '0 && cfg2_q == '0 && !start_q));
    assert_seq_commit_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst && !wr_cfg1) |=> $stable(seq_live_q));

endmodule

// File: rtl/smon_status.sv
module smon_status #(
    parameter int N_CH  = 4,
    parameter int RES_W = 16,
    parameter int CH_W  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       srst,
    input  logic                       rd_stat,
    input  logic                       cv_eoc,
    input  logic                       cv_eos,
    input  logic [CH_W-1:0]            cv_chan,
    input  logic [RES_W-1:0]           cv_data,
    output logic                       eoc_q,
    output logic                       eos_q,
    output logic [N_CH-1:0][RES_W-1:0] res_q
);

    logic eoc_d, eos_d;

    // completion wins over a same-cycle read clear
    always_comb begin
        eoc_d = eoc_q;
        eos_d = eos_q;
        if (rd_stat) begin
            eoc_d = 1'b0;
            eos_d = 1'b0;
        end
        if (cv_eoc) eoc_d = 1'b1;
        if (cv_eos) eos_d = 1'b1;
        if (srst) begin
            eoc_d = 1'b0;
            eos_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eoc_q <= 1'b0;
            eos_q <= 1'b0;
        end else begin
            eoc_q <= eoc_d;
            eos_q <= eos_d;
        end
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_res
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q[g] <= '0;
            end else if (srst) begin
                res_q[g] <= '0;
            end else if (cv_eoc && cv_chan == CH_W'(g)) begin
                res_q[g] <= cv_data;
            end
        end

        assert_result_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (cv_eoc && !srst && cv_chan == CH_W'(g)) |=> (res_q[g] == $past(cv_data)));
    end

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !cv_eoc && !cv_eos) |=> (!eoc_q && !eos_q));
    assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_eoc && !srst) |=> eoc_q);

endmodule

// File: rtl/smon_regfile.sv
module smon_regfile #(
    parameter int          DATA_W  = 32,
    parameter int          ADDR_W  = 12,
    parameter int          RES_W   = 16,
    parameter int          N_CH    = 4,
    parameter int          SEQ_W   = 16,
    parameter int          DIV_W   = 8,
    parameter int          RST_LEN = 16,
    parameter logic [31:0] KEY     = 32'h0000_000A
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic                       ext_start,
    output logic                       cnv_rst,
    output logic                       cnv_single,
    output logic                       cnv_cont,
    output logic [smon_pkg::CHAN_W-1:0] cnv_chan,
    output logic [DIV_W-1:0]           cnv_div,
    output logic [SEQ_W-1:0]           cnv_seq,
    output logic                       cnv_trig,
    input  logic                       cv_eoc,
    input  logic                       cv_eos,
    input  logic [((N_CH > 1) ? $clog2(N_CH) : 1)-1:0] cv_chan,
    input  logic [RES_W-1:0]           cv_data
);
    import smon_pkg::*;

    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;

    logic                       srst;
    logic                       wr_ok;
    logic                       wr_key, wr_cfg0, wr_cfg1, wr_cfg2, wr_seq, wr_start;
    logic                       rd_stat;
    logic [DATA_W-1:0]          cfg0_q, cfg1_q, cfg2_q;
    logic [SEQ_W-1:0]           seq_pend_q, seq_live_q;
    logic                       start_q;
    logic                       eoc_q, eos_q;
    logic [N_CH-1:0][RES_W-1:0] res_q;

    // address decode
    assign wr_ok    = bus_wr && !srst;
    assign wr_key   = wr_ok && (bus_addr == ADDR_W'(OFF_KEY));
    assign wr_cfg0  = wr_ok && (bus_addr == ADDR_W'(OFF_CFG0));
    assign wr_cfg1  = wr_ok && (bus_addr == ADDR_W'(OFF_CFG1));
    assign wr_cfg2  = wr_ok && (bus_addr == ADDR_W'(OFF_CFG2));
    assign wr_seq   = wr_ok && (bus_addr == ADDR_W'(OFF_SEQ));
    assign wr_start = wr_ok && (bus_addr == ADDR_W'(OFF_START));
    assign rd_stat  = bus_rd && (bus_addr == ADDR_W'(OFF_STAT));

    smon_softrst #(
        .DATA_W  (DATA_W),
        .RST_LEN (RST_LEN),
        .KEY     (KEY)
    ) u_rst (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (wr_key),
        .key_data (bus_wdata),
        .srst     (srst)
    );

    smon_cfg #(
        .DATA_W (DATA_W),
        .SEQ_W  (SEQ_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .srst       (srst),
        .wr_cfg0    (wr_cfg0),
        .wr_cfg1    (wr_cfg1),
        .wr_cfg2    (wr_cfg2),
        .wr_seq     (wr_seq),
        .wr_start   (wr_start),
        .wdata      (bus_wdata),
        .cfg0_q     (cfg0_q),
        .cfg1_q     (cfg1_q),
        .cfg2_q     (cfg2_q),
        .seq_pend_q (seq_pend_q),
        .seq_live_q (seq_live_q),
        .start_q    (start_q)
    );

    smon_status #(
        .N_CH  (N_CH),
        .RES_W (RES_W),
        .CH_W  (CH_W)
    ) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .srst    (srst),
        .rd_stat (rd_stat),
        .cv_eoc  (cv_eoc),
        .cv_eos  (cv_eos),
        .cv_chan (cv_chan),
        .cv_data (cv_data),
        .eoc_q   (eoc_q),
        .eos_q   (eos_q),
        .res_q   (res_q)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_CFG0)) bus_rdata = cfg0_q;
        if (bus_addr == ADDR_W'(OFF_CFG1)) bus_rdata = cfg1_q;
        if (bus_addr == ADDR_W'(OFF_CFG2)) bus_rdata = cfg2_q;
        if (bus_addr == ADDR_W'(OFF_SEQ))  bus_rdata = DATA_W'(seq_pend_q);
        if (bus_addr == ADDR_W'(OFF_START)) bus_rdata = DATA_W'(start_q);
        if (bus_addr == ADDR_W'(OFF_STAT)) bus_rdata = DATA_W'({eos_q, eoc_q});
        for (int c = 0; c < N_CH; c++) begin
            if (bus_addr == ADDR_W'(OFF_RES) + ADDR_W'(4 * c)) bus_rdata = DATA_W'(res_q[c]);
        end
    end

    // converter-facing fields
    assign cnv_rst    = srst;
    assign cnv_single = cfg1_q[BIT_SEQ_HI] & cfg1_q[BIT_SEQ_LO];
    assign cnv_cont   = ~cfg0_q[BIT_EVENT];
    assign cnv_chan   = cfg0_q[CHAN_W-1:0];
    assign cnv_div    = cfg2_q[DIV_LO +: DIV_W];
    assign cnv_seq    = seq_live_q;
    assign cnv_trig   = cfg0_q[BIT_EVENT] & (start_q | ext_start);

    assert_trig_idle_in_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!cnv_trig || ext_start));

endmodule

// File: tb/sim_smon_regfile.sv
`timescale 1ns/1ps
module sim_smon_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ext_start = 1'b0;
    logic        cnv_rst, cnv_single, cnv_cont, cnv_trig;
    logic [4:0]  cnv_chan;
    logic [7:0]  cnv_div;
    logic [15:0] cnv_seq;
    logic        cv_eoc = 1'b0, cv_eos = 1'b0;
    logic [1:0]  cv_chan = '0;
    logic [15:0] cv_data = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    smon_regfile u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_start(ext_start), .cnv_rst(cnv_rst), .cnv_single(cnv_single),
        .cnv_cont(cnv_cont), .cnv_chan(cnv_chan), .cnv_div(cnv_div),
        .cnv_seq(cnv_seq), .cnv_trig(cnv_trig), .cv_eoc(cv_eoc),
        .cv_eos(cv_eos), .cv_chan(cv_chan), .cv_data(cv_data)
    );

    // {is_read, addr, wdata, expected}
    localparam int NV = 12;
    localparam logic [76:0] VEC [NV] = '{
        {1'b0, 12'h100, 32'h0000_0203, 32'h0},
        {1'b1, 12'h100, 32'h0,         32'h0000_0203},
        {1'b0, 12'h104, 32'h0000_3000, 32'h0},
        {1'b1, 12'h104, 32'h0,         32'h0000_3000},
        {1'b0, 12'h108, 32'h0000_2000, 32'h0},
        {1'b1, 12'h108, 32'h0,         32'h0000_2000},
        {1'b0, 12'h120, 32'h0000_000F, 32'h0},
        {1'b1, 12'h120, 32'h0,         32'h0000_000F},
        {1'b1, 12'h014, 32'h0,         32'h0},
        {1'b1, 12'h200, 32'h0,         32'h0},
        {1'b1, 12'h20C, 32'h0,         32'h0},
        {1'b1, 12'h010, 32'h0,         32'h0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        logic [31:0] got;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 got = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, got, exp);
    endtask

    task automatic pulse(input logic eoc, input logic eos, input logic [1:0] ch, input logic [15:0] d);
        @(negedge clk);
        cv_eoc = eoc; cv_eos = eos; cv_chan = ch; cv_data = d;
        @(negedge clk);
        cv_eoc = 1'b0; cv_eos = 1'b0;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1'b1;
            finish_run();
        end
    end

    initial begin
        int n;
        logic [31:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 cnv_rst", 32'(cnv_rst), 32'h0);
        rd(12'h100, 32'h0, "R1 cfg0");
        rd(12'h014, 32'h0, "R1 status");
        rd(12'h204, 32'h0, "R1 result1");

        // table walk: R12 readback, R10 pending seq readback
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][76]) rd(VEC[i][75:64], VEC[i][31:0], "R12 table");
            else            wr(VEC[i][75:64], VEC[i][63:32]);
        end

        check("R4 single", 32'(cnv_single), 32'h1);
        check("R5 cont", 32'(cnv_cont), 32'h0);
        check("R5 chan", 32'(cnv_chan), 32'h3);
        check("R11 div", 32'(cnv_div), 32'd32);
        check("R10 seq not committed", 32'(cnv_seq), 32'h0);
        wr(12'h104, 32'h0000_1000);
        check("R10 seq committed", 32'(cnv_seq), 32'h000F);
        check("R4 single off", 32'(cnv_single), 32'h0);

        // R6 trigger OR in event mode
        @(negedge clk); ext_start = 1'b1; #1;
        check("R6 pin", 32'(cnv_trig), 32'h1);
        @(negedge clk); ext_start = 1'b0; #1;
        check("R6 idle", 32'(cnv_trig), 32'h0);
        wr(12'h010, 32'h1);
        check("R6 reg", 32'(cnv_trig), 32'h1);
        wr(12'h010, 32'h0);
        check("R6 reg clear", 32'(cnv_trig), 32'h0);
        wr(12'h100, 32'h0000_0003);
        check("R5 cont on", 32'(cnv_cont), 32'h1);
        @(negedge clk); ext_start = 1'b1; #1;
        check("R6 continuous gated", 32'(cnv_trig), 32'h0);
        @(negedge clk); ext_start = 1'b0;

        // R7 flags and read clear
        rd(12'h014, 32'h0, "R7 clear before");
        pulse(1'b1, 1'b0, 2'd3, 16'hBEEF);
        rd(12'h014, 32'h1, "R7 eoc set");
        rd(12'h014, 32'h0, "R7 eoc cleared");
        pulse(1'b0, 1'b1, 2'd0, 16'h0);
        rd(12'h014, 32'h2, "R7 eos set");
        rd(12'h014, 32'h0, "R7 eos cleared");

        // R9 results
        rd(12'h20C, 32'h0000_BEEF, "R9 ch3");
        pulse(1'b1, 1'b0, 2'd0, 16'hFFFF);
        rd(12'h200, 32'h0000_FFFF, "R9 ch0 upper zero");
        rd(12'h204, 32'h0, "R9 ch1 untouched");

        // R8 read and completion in same cycle
        rd(12'h014, 32'h1, "R8 pre");
        @(negedge clk);
        bus_addr = 12'h014; bus_rd = 1'b1; cv_eoc = 1'b1; cv_chan = 2'd2; cv_data = 16'h0055;
        #1 got = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; cv_eoc = 1'b0;
        check("R8 old value", got, 32'h0);
        rd(12'h014, 32'h1, "R8 flag kept");
        rd(12'h014, 32'h0, "R8 then cleared");

        // R2 wrong key ignored
        wr(12'h000, 32'h0000_0005);
        n = 0;
        for (int k = 0; k < 20; k++) begin
            if (cnv_rst) n++;
            @(negedge clk);
        end
        check("R2 wrong key", 32'(n), 32'd0);
        rd(12'h100, 32'h0000_0003, "R2 cfg kept");

        // R2/R3 keyed reset, write during hold
        wr(12'h000, 32'h0000_000A);
        n = 0;
        if (cnv_rst) n++;
        bus_addr = 12'h100; bus_wdata = 32'h0000_0203; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        while (cnv_rst && n < 40) begin
            n++;
            @(negedge clk);
        end
        check("R2 hold length", 32'(n), 32'd16);
        rd(12'h100, 32'h0, "R3 cfg0 zero");
        rd(12'h104, 32'h0, "R3 cfg1 zero");
        rd(12'h20C, 32'h0, "R3 results zero");
        check("R3 seq zero", 32'(cnv_seq), 32'h0);

        done = 1'b1;
        finish_run();
    end

endmodule